// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block sits beside the access controller of an asynchronous-strobe DRAM and owns two jobs the access path must never forget: bringing the memory out of power-on, and keeping every row refreshed afterwards. Once reset is released, it stays quiet for a parameterized pause. It then runs a fixed number of wake-up strobe cycles and raises a ready flag. From then on it issues one refresh every refresh interval. Each refresh is a strobe cycle in which the column strobe goes low before the row strobe, so the memory steps through its rows with its own internal row counter. Address, data, write-enable and output-enable take no part.

The access controller asks for the strobes with a level request. It holds them for as long as the grant stays high. Refresh slots that expire while the controller holds the bus are counted in a small pending counter, and they are replayed back-to-back once the bus is released. A queued refresh wins over a fresh request. If too many slots pile up, the retention deadline is treated as missed: an overdue flag is raised, and after the bus is next released the ready flag drops and the whole wake-up run is repeated before any further grant. All times are parameters counted in clock cycles.

Top module: `dref_seq`

## Requirements
- R1: While reset is asserted, ready, grant and overdue are 0 and both strobes (active low) are 1.
- R2: After reset release, no strobe goes low for the first PAUSE_CYC cycles, and the first column-strobe fall comes no later than PAUSE_CYC+3 cycles.
- R3: After the pause, exactly WAKE_CNT refresh strobe cycles are issued, and ready then rises with both strobes high.
- R4: In every refresh cycle, the column strobe is low for at least CSR_CYC cycles before the row strobe falls. It stays low for at least CHR_CYC cycles after that fall, and the row strobe stays low for at least RAS_LOW_CYC cycles.
- R5: Between a row-strobe rise and the next row-strobe fall, at least RAS_PRE_CYC cycles pass.
- R6: With ready high and no request, consecutive refresh cycles start exactly REF_INTERVAL_CYC cycles apart.
- R7: Grant rises only in answer to a request while ready is high, and never while the strobes are active. It falls in the cycle after the request is withdrawn.
- R8: No refresh strobe is issued while grant is high. Every refresh slot that expired during the grant is issued, back-to-back, after the release.
- R9: While the pending count is at or below OVERDUE_TH, overdue stays 0. When it exceeds OVERDUE_TH, overdue rises, but the current grant is kept. After the release, ready falls within two cycles, WAKE_CNT refresh cycles run, ready rises again, and overdue and the pending count are cleared.
- R10: When refreshes are pending and the bus is free, they run before a new request is granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_req_i | input | 1 | Access controller requests the memory strobes |
| acc_gnt_o | output | 1 | Strobes handed to the access controller |
| ready_o | output | 1 | Power-up or repeated wake-up complete |
| overdue_o | output | 1 | Pending refreshes exceeded the threshold |
| ref_active_o | output | 1 | A refresh strobe cycle is in progress |
| ras_n_o | output | 1 | Row strobe during refresh, active low |
| cas_n_o | output | 1 | Column strobe during refresh, active low |

## Verification
The assertions assume that reset is released between clock edges. They also assume that the access controller keeps its request high for the whole time it uses the bus and drops it only between its own memory cycles. Under that assumption, a grant is never withdrawn in the middle of an access. The stimulus changes the request only on falling clock edges. It holds the request across whole refresh intervals, and it starts each hold a fixed number of cycles after a refresh. This makes the number of refresh slots that expire during a hold known in advance.

// File: rtl/dref_pkg.sv
package dref_pkg;

    typedef enum logic [1:0] {
        CTL_PAUSE,
        CTL_WAKE,
        CTL_IDLE,
        CTL_REF
    } ctl_state_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_HOLD,
        PH_LOW,
        PH_PRE
    } cbr_phase_e;

endpackage

// File: rtl/dref_tick.sv
// Free-running divider: pulses tick_o once every LIMIT enabled cycles.
module dref_tick #(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic clr_i,
    output logic tick_o
);
    localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tick_st_t;

    tick_st_t q, d;

    always_comb begin
        d      = q;
        tick_o = 1'b0;
        if (clr_i) begin
            d.cnt = '0;
        end else if (en_i) begin
            if (q.cnt == LAST) begin
                d.cnt  = '0;
                tick_o = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end
endmodule

// File: rtl/dref_cbr.sv
// One column-before-row refresh strobe cycle per start pulse.
module dref_cbr #(
    parameter int unsigned CSR_CYC     = 2,
    parameter int unsigned CHR_CYC     = 2,
    parameter int unsigned RAS_LOW_CYC = 8,
    parameter int unsigned RAS_PRE_CYC = 5
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    output logic busy_o,
    output logic done_o,
    output logic ras_n_o,
    output logic cas_n_o
);
    import dref_pkg::*;

    localparam int unsigned LOW_REST = RAS_LOW_CYC - CHR_CYC;
    localparam int unsigned M1 = (CSR_CYC > CHR_CYC) ? CSR_CYC : CHR_CYC;
    localparam int unsigned M2 = (LOW_REST > RAS_PRE_CYC) ? LOW_REST : RAS_PRE_CYC;
    localparam int unsigned MAXV = (M1 > M2) ? M1 : M2;
    localparam int unsigned CW = $clog2(MAXV + 1);
    localparam logic [CW-1:0] LD_SETUP = CW'(CSR_CYC - 1);
    localparam logic [CW-1:0] LD_HOLD  = CW'(CHR_CYC - 1);
    localparam logic [CW-1:0] LD_LOW   = CW'(LOW_REST - 1);
    localparam logic [CW-1:0] LD_PRE   = CW'(RAS_PRE_CYC - 1);

    typedef struct packed {
        cbr_phase_e    phase;
        logic [CW-1:0] cnt;
    } cbr_st_t;

    cbr_st_t q, d;

    always_comb begin
        d      = q;
        done_o = 1'b0;
        unique case (q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    d.phase = PH_SETUP;
                    d.cnt   = LD_SETUP;
                end
            end
            PH_SETUP: begin
                if (q.cnt == '0) begin
                    d.phase = PH_HOLD;
                    d.cnt   = LD_HOLD;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            PH_HOLD: begin
                if (q.cnt == '0) begin
                    d.phase = PH_LOW;
                    d.cnt   = LD_LOW;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            PH_LOW: begin
                if (q.cnt == '0) begin
                    d.phase = PH_PRE;
                    d.cnt   = LD_PRE;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            PH_PRE: begin
                if (q.cnt == '0) begin
                    d.phase = PH_IDLE;
                    done_o  = 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.phase <= PH_IDLE;
            q.cnt   <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy_o  = (q.phase != PH_IDLE);
    assign ras_n_o = !((q.phase == PH_HOLD) || (q.phase == PH_LOW));
    assign cas_n_o = !((q.phase == PH_SETUP) || (q.phase == PH_HOLD));
endmodule

// File: rtl/dref_pending.sv
// Saturating count of owed refreshes with a sticky overdue flag.
module dref_pending #(
    parameter int unsigned PEND_W     = 3,
    parameter int unsigned OVERDUE_TH = 3
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic inc_i,
    input  logic dec_i,
    input  logic clr_i,
    output logic nonzero_o,
    output logic overdue_o
);
    localparam logic [PEND_W-1:0] FULL = {PEND_W{1'b1}};
    localparam logic [PEND_W-1:0] TH   = PEND_W'(OVERDUE_TH);

    typedef struct packed {
        logic [PEND_W-1:0] cnt;
        logic              ovd;
    } pend_st_t;

    pend_st_t q, d;

    always_comb begin
        d = q;
        if (clr_i) begin
            d.cnt = '0;
            d.ovd = 1'b0;
        end else begin
            if (inc_i && !dec_i && (q.cnt != FULL)) d.cnt = q.cnt + 1'b1;
            if (dec_i && !inc_i && (q.cnt != '0))   d.cnt = q.cnt - 1'b1;
            d.ovd = q.ovd | (q.cnt > TH);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign nonzero_o = (q.cnt != '0);
    assign overdue_o = q.ovd;
endmodule

// File: rtl/dref_seq.sv
module dref_seq #(
    parameter int unsigned PAUSE_CYC        = 25000,
    parameter int unsigned WAKE_CNT         = 8,
    parameter int unsigned REF_INTERVAL_CYC = 1950,
    parameter int unsigned CSR_CYC          = 2,
    parameter int unsigned CHR_CYC          = 2,
    parameter int unsigned RAS_LOW_CYC      = 8,
    parameter int unsigned RAS_PRE_CYC      = 5,
    parameter int unsigned PEND_W           = 3,
    parameter int unsigned OVERDUE_TH       = 3
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic acc_req_i,
    output logic acc_gnt_o,
    output logic ready_o,
    output logic overdue_o,
    output logic ref_active_o,
    output logic ras_n_o,
    output logic cas_n_o
);
    import dref_pkg::*;

    localparam int unsigned WCW = (WAKE_CNT > 1) ? $clog2(WAKE_CNT) : 1;
    localparam logic [WCW-1:0] WAKE_LAST = WCW'(WAKE_CNT - 1);

    typedef struct packed {
        ctl_state_e     state;
        logic [WCW-1:0] wake_cnt;
        logic           ready;
        logic           gnt;
    } ctl_st_t;

    ctl_st_t q, d;

    logic pause_tick, ivl_tick;
    logic seq_start, seq_busy, seq_done;
    logic pend_clr, pend_dec, pend_nz, pend_ovd;

    dref_tick #(.LIMIT(PAUSE_CYC)) i_pause (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (q.state == CTL_PAUSE),
        .clr_i  (1'b0),
        .tick_o (pause_tick)
    );

    dref_tick #(.LIMIT(REF_INTERVAL_CYC)) i_interval (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (q.ready),
        .clr_i  (pend_clr),
        .tick_o (ivl_tick)
    );

    dref_pending #(.PEND_W(PEND_W), .OVERDUE_TH(OVERDUE_TH)) i_pending (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .inc_i     (ivl_tick),
        .dec_i     (pend_dec),
        .clr_i     (pend_clr),
        .nonzero_o (pend_nz),
        .overdue_o (pend_ovd)
    );

    dref_cbr #(
        .CSR_CYC     (CSR_CYC),
        .CHR_CYC     (CHR_CYC),
        .RAS_LOW_CYC (RAS_LOW_CYC),
        .RAS_PRE_CYC (RAS_PRE_CYC)
    ) i_cbr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (seq_start),
        .busy_o  (seq_busy),
        .done_o  (seq_done),
        .ras_n_o (ras_n_o),
        .cas_n_o (cas_n_o)
    );

    always_comb begin
        d         = q;
        seq_start = 1'b0;
        pend_clr  = 1'b0;
        pend_dec  = 1'b0;
        unique case (q.state)
            CTL_PAUSE: begin
                if (pause_tick) d.state = CTL_WAKE;
            end
            CTL_WAKE: begin
                seq_start = !seq_busy;
                if (seq_done) begin
                    if (q.wake_cnt == WAKE_LAST) begin
                        d.state    = CTL_IDLE;
                        d.ready    = 1'b1;
                        d.wake_cnt = '0;
                    end else begin
                        d.wake_cnt = q.wake_cnt + 1'b1;
                    end
                end
            end
            CTL_IDLE: begin
                if (q.gnt) begin
                    if (!acc_req_i) d.gnt = 1'b0;
                end else if (pend_ovd) begin
                    d.state  = CTL_WAKE;
                    d.ready  = 1'b0;
                    pend_clr = 1'b1;
                end else if (pend_nz) begin
                    d.state = CTL_REF;
                end else if (acc_req_i) begin
                    d.gnt = 1'b1;
                end
            end
            CTL_REF: begin
                seq_start = !seq_busy;
                if (seq_done) begin
                    pend_dec = 1'b1;
                    d.state  = CTL_IDLE;
                end
            end
            default: d.state = CTL_PAUSE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.state    <= CTL_PAUSE;
            q.wake_cnt <= '0;
            q.ready    <= 1'b0;
            q.gnt      <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign acc_gnt_o    = q.gnt;
    assign ready_o      = q.ready;
    assign overdue_o    = pend_ovd;
    assign ref_active_o = seq_busy;
endmodule

// File: rtl/dref_seq_chk.sv
module dref_seq_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic acc_req_i,
    input logic acc_gnt_o,
    input logic ready_o,
    input logic overdue_o,
    input logic ras_n_o,
    input logic cas_n_o
);
    // R4: column strobe already low in the cycle before the row strobe falls
    a_r4_cas_leads_ras: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(ras_n_o) |-> (!cas_n_o && $past(!cas_n_o)));

    // R7: bus handed over only when ready and the strobes are idle
    a_r7_gnt_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc_gnt_o |-> (ready_o && ras_n_o && cas_n_o));

    // R7: grant answers a request
    a_r7_gnt_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(acc_gnt_o) |-> $past(acc_req_i));

    // R3: ready rises with the strobes released
    a_r3_ready_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ready_o) |-> (ras_n_o && cas_n_o));

    // R9: overdue clears only as the wake-up repeat begins
    a_r9_clear_with_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(overdue_o) |-> !ready_o);
endmodule

bind dref_seq dref_seq_chk i_dref_seq_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .acc_req_i (acc_req_i),
    .acc_gnt_o (acc_gnt_o),
    .ready_o   (ready_o),
    .overdue_o (overdue_o),
    .ras_n_o   (ras_n_o),
    .cas_n_o   (cas_n_o)
);

// File: tb/test_dref_seq.sv
`timescale 1ns/1ps
module test_dref_seq;
    localparam int unsigned P_PAUSE = 20;
    localparam int unsigned P_WAKE  = 8;
    localparam int unsigned P_IVL   = 50;
    localparam int unsigned P_CSR   = 2;
    localparam int unsigned P_CHR   = 2;
    localparam int unsigned P_RASL  = 6;
    localparam int unsigned P_RP    = 3;
    localparam int unsigned P_PW    = 3;
    localparam int unsigned P_TH    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_req = 1'b0;
    logic gnt, ready, overdue, ref_active, ras_n, cas_n;

    always #4 clk = ~clk;

    dref_seq #(
        .PAUSE_CYC(P_PAUSE), .WAKE_CNT(P_WAKE), .REF_INTERVAL_CYC(P_IVL),
        .CSR_CYC(P_CSR), .CHR_CYC(P_CHR), .RAS_LOW_CYC(P_RASL),
        .RAS_PRE_CYC(P_RP), .PEND_W(P_PW), .OVERDUE_TH(P_TH)
    ) i_dref_seq (
        .clk_i(clk), .rst_ni(rst_n), .acc_req_i(acc_req), .acc_gnt_o(gnt),
        .ready_o(ready), .overdue_o(overdue), .ref_active_o(ref_active),
        .ras_n_o(ras_n), .cas_n_o(cas_n)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int falls = 0;
    int ft [0:255];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // port monitor, sampled on falling edges
    bit ras_p = 1'b1, cas_p = 1'b1, seen_rise = 1'b0;
    int cas_lo_run = 0, ras_lo_run = 0, ras_hi_run = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (cas_p && !cas_n) begin
                falls++;
                if (falls < 256) ft[falls] = cyc;
            end
            if (ras_p && !ras_n) begin
                check(cas_lo_run >= int'(P_CSR), "R4 cas setup before ras fall", cas_lo_run, P_CSR);
                if (seen_rise)
                    check(ras_hi_run >= int'(P_RP), "R5 ras precharge", ras_hi_run, P_RP);
            end
            if (!cas_p && cas_n && !ras_n)
                check(ras_lo_run >= int'(P_CHR), "R4 cas hold after ras fall", ras_lo_run, P_CHR);
            if (!ras_p && ras_n) begin
                check(ras_lo_run >= int'(P_RASL), "R4 ras low width", ras_lo_run, P_RASL);
                seen_rise = 1'b1;
            end
            if (gnt)
                check(ready && ras_n && cas_n, "R7 grant with idle strobes", {ready, ras_n, cas_n}, 7);
            if (!ready)
                check(!gnt, "R7 no grant before ready", gnt, 0);
            cas_lo_run = cas_n ? 0 : cas_lo_run + 1;
            ras_lo_run = ras_n ? 0 : ras_lo_run + 1;
            ras_hi_run = ras_n ? ras_hi_run + 1 : 0;
            ras_p = ras_n;
            cas_p = cas_n;
            if (cyc > 20000) begin
                errors++;
                $display("FAIL watchdog actual %0d expected %0d", cyc, 20000);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_fall();
        int n0;
        n0 = falls;
        for (int i = 0; i < 300 && falls == n0; i++) @(negedge clk);
    endtask

    initial begin
        int f0, t0;
        // R1: reset state
        wait_cycles(3);
        check(!ready && !gnt && !overdue, "R1 flags in reset", {ready, gnt, overdue}, 0);
        check(ras_n && cas_n, "R1 strobes in reset", {ras_n, cas_n}, 3);
        rst_n = 1'b1;

        // R2: power-up pause
        for (int i = 0; i < 200 && falls == 0; i++) @(negedge clk);
        t0 = ft[1];
        check(t0 >= int'(P_PAUSE) && t0 <= int'(P_PAUSE) + 3, "R2 first strobe after pause", t0, P_PAUSE);

        // R3: wake-up run
        for (int i = 0; i < 500 && !ready; i++) @(negedge clk);
        check(ready == 1'b1, "R3 ready after wake-up", ready, 1);
        check(falls == int'(P_WAKE), "R3 wake-up cycle count", falls, P_WAKE);

        // R6: periodic spacing with idle bus
        f0 = falls;
        for (int i = 0; i < 400 && falls < f0 + 4; i++) @(negedge clk);
        for (int k = f0 + 2; k <= f0 + 4; k++)
            check(ft[k] - ft[k-1] == int'(P_IVL), "R6 refresh spacing", ft[k] - ft[k-1], P_IVL);

        // R7, R8, R10: two slots deferred by a grant
        wait_fall();
        wait_cycles(15);
        acc_req = 1'b1;
        for (int i = 0; i < 4 && !gnt; i++) @(negedge clk);
        check(gnt == 1'b1, "R7 grant on request", gnt, 1);
        f0 = falls;
        wait_cycles(100);
        check(falls == f0, "R8 no strobe during grant", falls - f0, 0);
        check(overdue == 1'b0, "R9 no overdue at two pending", overdue, 0);
        acc_req = 1'b0;
        @(negedge clk);
        check(gnt == 1'b0, "R7 grant drops after release", gnt, 0);
        acc_req = 1'b1;
        for (int i = 0; i < 80 && !gnt; i++) @(negedge clk);
        check(gnt == 1'b1, "R10 grant after queued refreshes", gnt, 1);
        check(falls - f0 == 2, "R8 R10 deferred refreshes replayed first", falls - f0, 2);
        acc_req = 1'b0;
        wait_cycles(60);

        // R9: overdue and wake-up repeat
        wait_fall();
        wait_cycles(15);
        acc_req = 1'b1;
        for (int i = 0; i < 4 && !gnt; i++) @(negedge clk);
        wait_cycles(260);
        check(overdue == 1'b1, "R9 overdue raised", overdue, 1);
        check(gnt && ready, "R9 grant kept while overdue", {gnt, ready}, 3);
        f0 = falls;
        acc_req = 1'b0;
        wait_cycles(2);
        check(ready == 1'b0, "R9 ready drops for repeat", ready, 0);
        for (int i = 0; i < 400 && !ready; i++) @(negedge clk);
        check(ready == 1'b1, "R9 ready returns", ready, 1);
        check(falls - f0 == int'(P_WAKE), "R9 repeat cycle count", falls - f0, P_WAKE);
        check(overdue == 1'b0, "R9 overdue cleared", overdue, 0);
        f0 = falls;
        wait_cycles(20);
        check(falls == f0, "R9 pending cleared", falls - f0, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule